// File: doc/BRIEF.md
# Memory Pattern Self-Test Sequencer

A built-in test engine that sits in front of the job port of a serial memory controller and checks the whole memory path on request. A start pulse launches a fixed four-job sequence on a small block at a fixed base address. It writes a block filled with one byte pattern, reads the block back and compares it, then writes the bitwise complement of that pattern, reads it back and compares again. The test ends with a one-cycle done pulse, together with either a pass flag or a 4-bit error code that names the stage that failed.

The controller is driven through a single-cycle job request that carries the direction, base address, length and write byte. The controller answers each job with a finished pulse or a timeout pulse, and on reads it delivers the returned bytes one at a time on a valid strobe. The sequencer keeps its own read-back buffer and clears it before every read. If too few bytes come back, the zeros left in the buffer cannot match either pattern, so the compare fails.

Top module: `mem_pattern_selftest`

## Requirements
- R1: After reset, job_req_o, done_o and pass_o are 0 and err_o is 0.
- R2: A start_i pulse while the sequencer is idle and ctl_idle_i is 1 is accepted. In the next cycle job_req_o is 1 for one cycle with job_wr_o=1, job_addr_o=0, job_len_o=10 and job_wdata_o=0xCC, and pass_o and err_o read 0.
- R3: A start_i pulse while the sequencer is idle but ctl_idle_i is 0 is refused. In the next cycle done_o pulses with pass_o=0 and err_o=1, and no job is issued.
- R4: The jobs follow the fixed order write 0xCC, read, write 0x33, read. A read job has job_wr_o=0. job_wdata_o is 0xCC for the first pass and 0x33 for the second.
- R5: Each job waits for ctl_done_i or ctl_timeout_i. A write's successor is requested in the cycle after its finished pulse. job_req_o is never high two cycles in a row, and start_i has no effect while a test runs.
- R6: A timeout ends the test one cycle later with done_o=1, pass_o=0 and a stage code: 2 for write 1, 3 for read 1, 5 for write 2, 6 for read 2. If timeout and finished come in the same cycle, the timeout wins.
- R7: Issuing a read job clears all 10 buffer bytes to 0. Returned bytes fill the buffer in arrival order. Bytes beyond the tenth are ignored, and missing bytes stay 0.
- R8: A buffer byte that differs from the pass pattern ends the test two cycles after the read's finished pulse, with done_o=1, pass_o=0 and err_o=4 (pass 1) or 7 (pass 2).
- R9: If both compares match, done_o=1, pass_o=1 and err_o=0 two cycles after the last read's finished pulse. After a matching first compare, the second write is requested at that same point.
- R10: done_o is a single-cycle pulse. pass_o and err_o hold their final values until the next start_i is taken in the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for a test run |
| ctl_idle_i | input | 1 | Controller ready to accept a job |
| ctl_done_i | input | 1 | Controller finished the current job |
| ctl_timeout_i | input | 1 | Controller gave up on the current job |
| rd_valid_i | input | 1 | One returned read byte is valid |
| rd_data_i | input | 8 | Returned read byte |
| job_req_o | output | 1 | One-cycle job request |
| job_wr_o | output | 1 | Job direction, 1 = write |
| job_addr_o | output | 15 | Job start address |
| job_len_o | output | 4 | Job byte count |
| job_wdata_o | output | 8 | Byte to write in every location |
| done_o | output | 1 | One-cycle end-of-test pulse |
| pass_o | output | 1 | Test passed (held) |
| err_o | output | 4 | Failure code (held) |

## Verification
Results fall due at fixed distances. A refusal, a timeout code and the request that follows a write appear one cycle after the edge that samples the stimulus. A compare verdict, and the request that follows it, appear two cycles after the read's finished pulse, because of the compare cycle. A behavioural model in the bench advances on the same edge as the design and is compared with every output on the following falling edge, so each result is checked in exactly the cycle it is due. The scenarios cover success, each timeout stage (one with a simultaneous finished pulse), a wrong byte in each pass, a short read that follows a full one, surplus read bytes, a refused start and a start pulse during a run.

// File: rtl/mem_pattern_selftest.sv
module mem_pattern_selftest #(
  parameter int NBYTES = 10,
  parameter int ADDR_W = 15,
  parameter logic [ADDR_W-1:0] BASE = '0,
  parameter logic [7:0] PAT_A = 8'hCC
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic                          ctl_idle_i,
  input  logic                          ctl_done_i,
  input  logic                          ctl_timeout_i,
  input  logic                          rd_valid_i,
  input  logic [7:0]                    rd_data_i,
  output logic                          job_req_o,
  output logic                          job_wr_o,
  output logic [ADDR_W-1:0]             job_addr_o,
  output logic [$clog2(NBYTES+1)-1:0]   job_len_o,
  output logic [7:0]                    job_wdata_o,
  output logic                          done_o,
  output logic                          pass_o,
  output logic [3:0]                    err_o
);
  localparam int LEN_W = $clog2(NBYTES+1);
  localparam logic [7:0] PAT_B = ~PAT_A;
  localparam logic [3:0] E_REFUSE = 4'd1;
  localparam logic [3:0] E_MIS1   = 4'd4;
  localparam logic [3:0] E_MIS2   = 4'd7;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_CMP} st_t;

  st_t              st;
  logic [1:0]       stage;
  logic [7:0]       rbuf [NBYTES];
  logic [LEN_W-1:0] ridx;
  logic             bad;
  logic [3:0]       to_code;

  wire is_rd   = stage[0];
  wire [7:0] pat = stage[1] ? PAT_B : PAT_A;
  wire issue_rd = (st == S_RUN) && !ctl_timeout_i && ctl_done_i && !is_rd;
  wire capture  = (st == S_RUN) && is_rd && rd_valid_i && (ridx < LEN_W'(NBYTES));

  assign job_wr_o    = !is_rd;
  assign job_addr_o  = BASE;
  assign job_len_o   = LEN_W'(NBYTES);
  assign job_wdata_o = pat;

  always_comb begin
    case (stage)
      2'd0:    to_code = 4'd2;
      2'd1:    to_code = 4'd3;
      2'd2:    to_code = 4'd5;
      default: to_code = 4'd6;
    endcase
  end

  always_comb begin
    bad = 1'b0;
    for (int i = 0; i < NBYTES; i++)
      if (rbuf[i] != pat) bad = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ridx <= '0;
      for (int i = 0; i < NBYTES; i++) rbuf[i] <= '0;
    end else if (issue_rd) begin
      ridx <= '0;
      for (int i = 0; i < NBYTES; i++) rbuf[i] <= '0;
    end else if (capture) begin
      rbuf[ridx] <= rd_data_i;
      ridx <= ridx + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      stage     <= '0;
      job_req_o <= 1'b0;
      done_o    <= 1'b0;
      pass_o    <= 1'b0;
      err_o     <= '0;
    end else begin
      job_req_o <= 1'b0;
      done_o    <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start_i) begin
            pass_o <= 1'b0;
            if (ctl_idle_i) begin
              st        <= S_RUN;
              stage     <= '0;
              job_req_o <= 1'b1;
              err_o     <= '0;
            end else begin
              done_o <= 1'b1;
              err_o  <= E_REFUSE;
            end
          end
        end
        S_RUN: begin
          if (ctl_timeout_i) begin
            st     <= S_IDLE;
            done_o <= 1'b1;
            err_o  <= to_code;
          end else if (ctl_done_i) begin
            if (is_rd) begin
              st <= S_CMP;
            end else begin
              stage     <= stage + 1'b1;
              job_req_o <= 1'b1;
            end
          end
        end
        default: begin
          if (bad) begin
            st     <= S_IDLE;
            done_o <= 1'b1;
            err_o  <= stage[1] ? E_MIS2 : E_MIS1;
          end else if (stage == 2'd3) begin
            st     <= S_IDLE;
            done_o <= 1'b1;
            pass_o <= 1'b1;
          end else begin
            st        <= S_RUN;
            stage     <= stage + 1'b1;
            job_req_o <= 1'b1;
          end
        end
      endcase
    end
  end

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start_i && ctl_idle_i) |=> (job_req_o && job_wr_o && job_wdata_o == PAT_A && err_o == 4'd0));
  // R3
  refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && start_i && !ctl_idle_i) |=> (done_o && !pass_o && err_o == E_REFUSE && !job_req_o));
  // R6
  timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN && ctl_timeout_i) |=> (done_o && !pass_o && (err_o == 4'd2 || err_o == 4'd3 || err_o == 4'd5 || err_o == 4'd6)));
  // R5
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    job_req_o |=> !job_req_o);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && !start_i) |=> ($stable(err_o) && $stable(pass_o)));
  // R9
  pass_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> (err_o == 4'd0));
endmodule

// File: tb/mem_pattern_selftest_bench.sv
module mem_pattern_selftest_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic start = 0, ctl_idle = 1, cdone = 0, tmo = 0, rd_valid = 0;
  logic [7:0] rd_data = 0;
  logic job_req, job_wr, done, pass;
  logic [14:0] job_addr;
  logic [3:0] job_len, err;
  logic [7:0] job_wdata;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  mem_pattern_selftest u_mem_pattern_selftest (
    .clk(clk), .rst_n(rst_n), .start_i(start), .ctl_idle_i(ctl_idle),
    .ctl_done_i(cdone), .ctl_timeout_i(tmo), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .job_req_o(job_req), .job_wr_o(job_wr), .job_addr_o(job_addr), .job_len_o(job_len),
    .job_wdata_o(job_wdata), .done_o(done), .pass_o(pass), .err_o(err));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  int m_st, m_stg, m_idx, m_err;
  bit m_req, m_done, m_pass, m_mis;
  int mb[10];
  int codes[4] = '{2, 3, 5, 6};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_stg = 0; m_idx = 0; m_req = 0; m_done = 0; m_pass = 0; m_err = 0;
      foreach (mb[i]) mb[i] = 0;
    end else begin
      m_req = 0; m_done = 0;
      if (m_st == 1 && (m_stg % 2) == 1 && rd_valid && m_idx < 10) begin
        mb[m_idx] = rd_data; m_idx++;
      end
      case (m_st)
        0: if (start) begin
             m_pass = 0;
             if (ctl_idle) begin m_st = 1; m_stg = 0; m_req = 1; m_err = 0; end
             else begin m_done = 1; m_err = 1; end
           end
        1: if (tmo) begin m_st = 0; m_done = 1; m_err = codes[m_stg]; end
           else if (cdone) begin
             if (m_stg % 2) m_st = 2;
             else begin
               m_stg++; m_req = 1; m_idx = 0;
               foreach (mb[i]) mb[i] = 0;
             end
           end
        default: begin
          m_mis = 0;
          foreach (mb[i]) if (mb[i] != ((m_stg >= 2) ? 'h33 : 'hCC)) m_mis = 1;
          if (m_mis) begin m_st = 0; m_done = 1; m_err = (m_stg >= 2) ? 7 : 4; end
          else if (m_stg == 3) begin m_st = 0; m_done = 1; m_pass = 1; end
          else begin m_stg++; m_req = 1; m_st = 1; end
        end
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2/R5 job_req_o", job_req, m_req);
      chk("R10 done_o", done, m_done);
      chk("R9 pass_o", pass, m_pass);
      chk("R6/R8 err_o", err, m_err);
      if (m_req) begin
        chk("R4 job_wr_o", job_wr, (m_stg % 2) == 0);
        chk("R4 job_wdata_o", job_wdata, (m_stg >= 2) ? 'h33 : 'hCC);
        chk("R2 job_addr_o", job_addr, 0);
        chk("R2 job_len_o", job_len, 10);
      end
    end
  end

  task automatic serve(input int stg, input int to_stg, input bit both, input int bad_stg,
                       input int bad_idx, input int bad_val, input int nb_stg, input int nb,
                       input int stop_stg, input bit glitch, output bit stop);
    int n;
    int p;
    p = (stg >= 2) ? 'h33 : 'hCC;
    n = (stg == nb_stg) ? nb : 10;
    while (!job_req) @(negedge clk);
    @(negedge clk); if (glitch) start = 1;
    @(negedge clk); start = 0;
    if (stg % 2) begin
      for (int i = 0; i < n; i++) begin
        rd_valid = 1;
        rd_data = (stg == bad_stg && i == bad_idx) ? 8'(bad_val) : (i >= 10 ? 8'h00 : 8'(p));
        @(negedge clk);
      end
      rd_valid = 0;
    end
    if (stg == to_stg) begin
      tmo = 1; cdone = both; @(negedge clk); tmo = 0; cdone = 0; stop = 1;
    end else begin
      cdone = 1; @(negedge clk); cdone = 0; stop = (stg == stop_stg);
    end
  endtask

  task automatic run_test(input int to_stg, input bit both, input int bad_stg, input int bad_idx,
                          input int bad_val, input int nb_stg, input int nb, input int stop_stg,
                          input bit glitch, input int exp_err, input int exp_pass, input string tag);
    bit stop;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int s = 0; s < 4; s++) begin
      serve(s, to_stg, both, bad_stg, bad_idx, bad_val, nb_stg, nb, stop_stg, glitch && s == 0, stop);
      if (stop) break;
    end
    repeat (4) @(negedge clk);
    chk({tag, " final err_o"}, err, exp_err);
    chk({tag, " final pass_o"}, pass, exp_pass);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset job_req_o", job_req, 0);
    chk("R1 reset done_o", done, 0);
    chk("R1 reset err_o", err, 0);
    rst_n = 1;
    @(negedge clk);
    ctl_idle = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk("R3 refused done_o", done, 1);
    chk("R3 refused err_o", err, 1);
    ctl_idle = 1;
    repeat (3) @(negedge clk);
    chk("R10 held err_o", err, 1);
    run_test(-1, 0, -1, 0, 0, -1, 10, -1, 1, 0, 1, "R9 R5 full pass");
    run_test(-1, 0, -1, 0, 0, 1, 9, 1, 0, 4, 0, "R7 short read");
    run_test(-1, 0, 3, 5, 'h13, -1, 10, 3, 0, 7, 0, "R8 mismatch pass2");
    run_test(-1, 0, 1, 0, 'hCD, -1, 10, 1, 0, 4, 0, "R8 mismatch pass1");
    run_test(-1, 0, 3, 11, 'h55, 3, 12, -1, 0, 0, 1, "R7 surplus bytes");
    run_test(0, 0, -1, 0, 0, -1, 10, -1, 0, 2, 0, "R6 timeout wr1");
    run_test(1, 0, -1, 0, 0, -1, 10, -1, 0, 3, 0, "R6 timeout rd1");
    run_test(2, 1, -1, 0, 0, -1, 10, -1, 0, 5, 0, "R6 timeout wr2 with done");
    run_test(3, 0, -1, 0, 0, -1, 10, -1, 0, 6, 0, "R6 timeout rd2");
    run_test(-1, 0, -1, 0, 0, -1, 10, -1, 0, 0, 1, "R9 R4 pass again");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule